// File: doc/BRIEF.md
# SCK High-Time Uniformity Monitor

This block sits next to an SPI slave and runs on the slave's own clock. It uses an SCK that has already been synchronized into that clock domain. For each high phase of SCK inside a frame, it counts how many local clock cycles SCK stayed at 1. Within one frame the master keeps a fixed SCK rate, so every high phase should last about the same number of local cycles. When the eight clocks the slave has gathered actually belong to two neighbouring master frames, one high phase looks clearly longer or shorter than the others. The block detects this case.

The first high-phase length measured in a frame becomes the reference. Each later length is compared against that reference. A gap of one cycle is accepted, because the master and slave clocks are asynchronous and the count is rounded. A larger gap raises a sticky offset-error flag. It also emits a one-cycle resynchronization pulse, which the slave uses as an end-of-frame event, and it discards the reference. The next high phase then acts as the first clock of a new frame. Deasserting the enable returns the counter, the reference and both outputs to their idle state.

Top module: `ofst_uniformity_mon`

## Requirements
- R1: After reset, `ofst_flag` and `resync_pulse` are both 0.
- R2: While `frame_act` is 1, the block counts the clock cycles in which `sck_sync` is sampled at 1. A 1-to-0 transition ends a high phase. When every high phase in a frame has the same count, no pulse appears and the flag does not change.
- R3: A high-phase count that differs from the frame's reference by exactly one is accepted: no pulse and no flag.
- R4: A high-phase count that differs from the reference by two or more sets `ofst_flag` and drives `resync_pulse` to 1. Both take effect at the first rising clock edge at which `sck_sync` is sampled at 0 after the long or short phase. The pulse lasts exactly one cycle.
- R5: The high-phase count saturates at 255 (all ones of the 8-bit default width) and does not wrap. Two phases of 300 and 256 cycles therefore compare equal.
- R6: The high phase that triggers a mismatch is not used as a reference. The next complete high phase becomes the new reference, and later phases are compared against it.
- R7: When `frame_act` is 0, the reference is discarded. The first high phase of the next frame sets a fresh reference whatever length the previous frame used.
- R8: `ofst_flag` stays at 1 until `ofst_clr` is sampled at 1 or `enable` is sampled at 0.
- R9: When `ofst_clr` and a new mismatch fall in the same cycle, the set wins and `ofst_flag` stays at 1.
- R10: While `enable` is 0, both outputs are 0 from the next edge on, and the reference is discarded. After re-enabling, the first high phase sets a new reference.
- R11: SCK activity while `frame_act` is 0 produces no pulse and no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slave local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; 0 clears all state |
| sck_sync | input | 1 | Serial clock already synchronized to `clk` |
| frame_act | input | 1 | 1 while the slave is selected and a frame is in progress |
| ofst_clr | input | 1 | Clears the sticky offset flag |
| ofst_flag | output | 1 | Sticky offset-error indication |
| resync_pulse | output | 1 | One-cycle end-of-frame / realign pulse |

## Verification
Two events can land on the same clock edge: the software clear of the sticky flag and the detection of a fresh mismatch. The bench forces them together by first setting the flag and building a new reference. It then raises `ofst_clr` on the same negative edge that drops SCK after an overlong high phase, so the clear request and the falling-edge comparison are both sampled at the next rising edge. The flag must read 1 afterwards, with one resync pulse counted. A separate clear cycle must then bring it to 0.

// File: rtl/ofst_chk_pkg.sv
package ofst_chk_pkg;

  // widest count the shared arithmetic handles
  localparam int WMAX = 16;
  typedef logic [WMAX-1:0] wide_t;

  // one step of a counter that sticks at lim
  function automatic wide_t sat_step(input wide_t v, input wide_t lim);
    wide_t r;
    if (v >= lim) r = lim;
    else          r = v + wide_t'(1);
    return r;
  endfunction

  // magnitude of the difference of two counts
  function automatic wide_t abs_gap(input wide_t a, input wide_t b);
    wide_t r;
    if (a > b) r = a - b;
    else       r = b - a;
    return r;
  endfunction

  // true when two counts are further apart than tol
  function automatic logic beyond_tol(input wide_t a, input wide_t b, input wide_t tol);
    return abs_gap(a, b) > tol;
  endfunction

endpackage

// File: rtl/sck_fall_det.sv
module sck_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  output logic fall_o
);
  logic sck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sck_q <= 1'b0;
    else        sck_q <= sck_in;
  end

  assign fall_o = sck_q & ~sck_in;

  // a fall is only reported after SCK was seen high on the previous edge
  p_fall_after_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> ($past(sck_in) && !sck_in));

endmodule

// File: rtl/sck_high_counter.sv
module sck_high_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sck_lvl,
  input  logic             sck_fall,
  output logic [CNT_W-1:0] count_o
);
  import ofst_chk_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam wide_t            LIM     = wide_t'(CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        count_o <= '0;
    else if (clr)      count_o <= '0;
    else if (sck_fall) count_o <= '0;
    else if (sck_lvl)  count_o <= CNT_W'(sat_step(wide_t'(count_o), LIM));
  end

  // count holds at its ceiling while SCK stays high
  p_count_saturates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == CNT_MAX && sck_lvl && !clr && !sck_fall) |=> (count_o == CNT_MAX));

  // a cleared block restarts from zero
  p_count_cleared_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (count_o == '0));

endmodule

// File: rtl/hi_ref_tracker.sv
module hi_ref_tracker #(
  parameter int CNT_W = 8,
  parameter int TOL   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             sck_fall,
  input  logic [CNT_W-1:0] count_i,
  output logic             mismatch_o
);
  import ofst_chk_pkg::*;

  localparam wide_t TOL_W = wide_t'(TOL);

  logic [CNT_W-1:0] ref_q;
  logic             ref_ok;
  logic             far;

  assign far        = beyond_tol(wide_t'(count_i), wide_t'(ref_q), TOL_W);
  assign mismatch_o = sck_fall & ref_ok & far;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q  <= '0;
      ref_ok <= 1'b0;
    end else if (clr) begin
      ref_q  <= '0;
      ref_ok <= 1'b0;
    end else if (sck_fall) begin
      if (!ref_ok) begin
        ref_q  <= count_i;
        ref_ok <= 1'b1;
      end else if (far) begin
        ref_ok <= 1'b0;
      end
    end
  end

  // a held reference is not disturbed between phase ends
  p_ref_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_ok && !clr && !sck_fall) |=> ($stable(ref_q) && ref_ok));

  // after a mismatch the next phase end captures a new reference
  p_realign_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch_o && !clr) |=> !ref_ok);

  // no reference survives a clear
  p_ref_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !ref_ok);

endmodule

// File: rtl/ofst_uniformity_mon.sv
module ofst_uniformity_mon #(
  parameter int CNT_W = 8,
  parameter int TOL   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic sck_sync,
  input  logic frame_act,
  input  logic ofst_clr,
  output logic ofst_flag,
  output logic resync_pulse
);
  logic             blk_clr;
  logic             sck_fall;
  logic [CNT_W-1:0] hi_count;
  logic             mismatch;

  assign blk_clr = ~enable | ~frame_act;

  sck_fall_det u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .sck_in (sck_sync),
    .fall_o (sck_fall)
  );

  sck_high_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (blk_clr),
    .sck_lvl  (sck_sync),
    .sck_fall (sck_fall),
    .count_o  (hi_count)
  );

  hi_ref_tracker #(.CNT_W(CNT_W), .TOL(TOL)) u_ref (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (blk_clr),
    .sck_fall   (sck_fall),
    .count_i    (hi_count),
    .mismatch_o (mismatch)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofst_flag    <= 1'b0;
      resync_pulse <= 1'b0;
    end else if (!enable) begin
      ofst_flag    <= 1'b0;
      resync_pulse <= 1'b0;
    end else begin
      resync_pulse <= mismatch;
      if (mismatch)      ofst_flag <= 1'b1;
      else if (ofst_clr) ofst_flag <= 1'b0;
    end
  end

  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resync_pulse |=> !resync_pulse);

  p_pulse_with_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    resync_pulse |-> ofst_flag);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ofst_flag && enable && !ofst_clr) |=> ofst_flag);

  p_set_beats_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mismatch && enable) |=> ofst_flag);

  p_disable_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!ofst_flag && !resync_pulse));

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_act |=> !resync_pulse);

endmodule

// File: tb/ofst_uniformity_mon_bench.sv
`timescale 1ns/1ps
module ofst_uniformity_mon_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic sck_sync = 1'b0;
  logic frame_act = 1'b0;
  logic ofst_clr = 1'b0;
  logic ofst_flag;
  logic resync_pulse;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ofst_uniformity_mon u_ofst_uniformity_mon (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .sck_sync     (sck_sync),
    .frame_act    (frame_act),
    .ofst_clr     (ofst_clr),
    .ofst_flag    (ofst_flag),
    .resync_pulse (resync_pulse)
  );

  // count resync pulses one ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (rst_n && resync_pulse === 1'b1) pulses++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one SCK period: hi cycles high, lo cycles low, starting at a negedge
  task automatic phase(input int hi, input int lo);
    sck_sync = 1'b1;
    repeat (hi) @(negedge clk);
    sck_sync = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic new_frame();
    frame_act = 1'b0;
    repeat (2) @(negedge clk);
    frame_act = 1'b1;
    @(negedge clk);
  endtask

  task automatic clear_flag();
    ofst_clr = 1'b1;
    @(negedge clk);
    ofst_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 flag", int'(ofst_flag), 0);
    chk("R1 pulse", int'(resync_pulse), 0);
  endtask

  task automatic t_uniform();
    int p0;
    new_frame();
    p0 = pulses;
    for (int i = 0; i < 8; i++) phase(4, 3);
    chk("R2 pulses", pulses - p0, 0);
    chk("R2 flag", int'(ofst_flag), 0);
  endtask

  task automatic t_tolerance();
    int p0;
    new_frame();
    p0 = pulses;
    phase(5, 3); phase(6, 3); phase(4, 3); phase(5, 2); phase(6, 4);
    chk("R3 pulses", pulses - p0, 0);
    chk("R3 flag", int'(ofst_flag), 0);
  endtask

  task automatic t_mismatch_realign();
    int p0;
    new_frame();
    p0 = pulses;
    phase(3, 3); phase(3, 3);
    sck_sync = 1'b1;
    repeat (6) @(negedge clk);
    chk("R4 flag before", int'(ofst_flag), 0);
    sck_sync = 1'b0;
    @(negedge clk);
    chk("R4 pulse edge", int'(resync_pulse), 1);
    chk("R4 flag set", int'(ofst_flag), 1);
    @(negedge clk);
    chk("R4 pulse width", int'(resync_pulse), 0);
    @(negedge clk);
    chk("R4 pulse count", pulses - p0, 1);
    // next full phase is the new reference (6)
    phase(6, 3); phase(6, 3); phase(7, 3);
    chk("R6 no repeat", pulses - p0, 1);
    phase(3, 3);
    chk("R6 new ref compared", pulses - p0, 2);
  endtask

  task automatic t_latch_clear();
    repeat (20) @(negedge clk);
    chk("R8 held", int'(ofst_flag), 1);
    clear_flag();
    chk("R8 cleared", int'(ofst_flag), 0);
  endtask

  task automatic t_collision();
    int p0;
    // make the flag 1 first
    new_frame();
    phase(4, 3); phase(9, 3);
    chk("R9 pre flag", int'(ofst_flag), 1);
    new_frame();
    p0 = pulses;
    phase(4, 3);
    sck_sync = 1'b1;
    repeat (9) @(negedge clk);
    sck_sync = 1'b0;
    ofst_clr = 1'b1;
    @(negedge clk);
    ofst_clr = 1'b0;
    chk("R9 set wins", int'(ofst_flag), 1);
    repeat (2) @(negedge clk);
    chk("R9 pulse", pulses - p0, 1);
    clear_flag();
    chk("R9 later clear", int'(ofst_flag), 0);
  endtask

  task automatic t_frame_ref();
    int p0;
    new_frame();
    p0 = pulses;
    phase(3, 3); phase(3, 3);
    new_frame();
    phase(9, 3); phase(9, 3); phase(10, 3);
    chk("R7 fresh ref", pulses - p0, 0);
    chk("R7 flag", int'(ofst_flag), 0);
  endtask

  task automatic t_saturate();
    int p0;
    new_frame();
    p0 = pulses;
    phase(300, 4); phase(256, 4); phase(255, 4);
    chk("R5 saturated equal", pulses - p0, 0);
    phase(254, 4);
    chk("R5 tol at top", pulses - p0, 0);
    phase(200, 4);
    chk("R5 far below", pulses - p0, 1);
    clear_flag();
  endtask

  task automatic t_idle();
    int p0;
    frame_act = 1'b0;
    @(negedge clk);
    p0 = pulses;
    phase(2, 3); phase(9, 3); phase(30, 2); phase(2, 3);
    chk("R11 pulses", pulses - p0, 0);
    chk("R11 flag", int'(ofst_flag), 0);
  endtask

  task automatic t_disable();
    int p0;
    new_frame();
    phase(3, 3); phase(8, 3);
    chk("R10 pre flag", int'(ofst_flag), 1);
    phase(3, 3);
    enable = 1'b0;
    @(negedge clk);
    chk("R10 flag off", int'(ofst_flag), 0);
    chk("R10 pulse off", int'(resync_pulse), 0);
    p0 = pulses;
    phase(3, 3); phase(12, 3);
    chk("R10 no detect", pulses - p0, 0);
    enable = 1'b1;
    @(negedge clk);
    phase(9, 3); phase(9, 3);
    chk("R10 ref dropped", pulses - p0, 0);
    chk("R10 flag stays", int'(ofst_flag), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    @(negedge clk);
    t_uniform();
    t_tolerance();
    t_mismatch_realign();
    t_latch_clear();
    t_collision();
    t_frame_ref();
    t_saturate();
    t_idle();
    t_disable();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule